// File: doc/BRIEF.md
# Paged Flash Erase Sequencer

This block erases a byte range of a serial flash that is organised in pages, where the page size need not be a power of two. A caller gives a start offset, a length in bytes, the page size in bytes and the bit position at which the page number sits inside the device's 24-bit command address, then pulses `start`. The block first converts offset and length into page units with a pair of sequential dividers. If either value is not a whole number of pages, it rejects the request at once.

Each erase step covers either one page or an aligned group of eight pages. The group erase is chosen whenever the current page number is a multiple of eight and at least eight pages remain. After each erase command the block polls the device status byte until the ready flag appears, waiting a programmable interval between polls. It gives up with a timeout error if the device stays busy too long.

The block does not shift bits itself. It hands single bytes to an external SPI shifter through a request/acknowledge handshake and holds a chip-select level that frames each command or status exchange.

Top module: `erase_seq`

## Requirements
- R1: When the page size is zero, or when the offset or the length is not an exact multiple of the page size, the block pulses `err_o` with `err_code` = 1 (alignment) and sends no byte frame to the shifter.
- R2: Each step uses opcode 0x50 (eight-page erase) when the current page number has its three low bits at zero and at least eight pages remain. Otherwise it uses opcode 0x81 (single-page erase).
- R3: Each erase command is one chip-select frame of four bytes: the opcode, command-address bits 23:16, command-address bits 15:8, then 0x00. The command address is the page number shifted left by `page_shift_in` and truncated to 24 bits.
- R4: After each erase command the block sends status frames of two bytes, 0xD7 then 0x00. It takes the byte returned with the second byte as status, and moves to the next step only when bit 7 of that status is 1.
- R5: Two successive status frames after the same command start at least `POLL_CYC` clock cycles apart.
- R6: If no ready status is seen within `TIMEOUT_CYC` cycles of the end of an erase command, the block pulses `err_o` with `err_code` = 2 (timeout) and sends no further command.
- R7: After a ready status, an eight-page erase advances the page number by eight and lowers the remaining count by eight. A single-page erase changes each by one. The block pulses `done_o` once no pages remain, and a zero length finishes with no frame at all.
- R8: A status byte delivered together with `spi_fail` is treated as 0x00 (not ready), and polling continues.
- R9: A `start` pulse while `busy` is high has no effect on the operation in progress or on its outcome.
- R10: `done_o` and `err_o` are single-cycle pulses, and exactly one of them occurs per accepted start. `err_code` keeps its value from the end of an operation until the next accepted start, and is 0 after a successful operation.
- R11: After reset, `busy`, `done_o`, `err_o`, `spi_cs` and `spi_req` are 0, and `err_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an erase using the values on the four request inputs |
| offset_in | input | ADDR_W | Start byte offset |
| length_in | input | ADDR_W | Length in bytes |
| page_size_in | input | PS_W | Page size in bytes |
| page_shift_in | input | SH_W | Bit position of the page number in the command address |
| busy | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse: range erased |
| err_o | output | 1 | One-cycle pulse: operation ended in error |
| err_code | output | 2 | 0 none, 1 alignment, 2 timeout; held until next start |
| spi_cs | output | 1 | Chip-select active level, high for the whole of a frame |
| spi_req | output | 1 | One-cycle request to shift out `spi_tx` |
| spi_tx | output | 8 | Byte to send |
| spi_ack | input | 1 | Shifter finished the requested byte |
| spi_rx | input | 8 | Byte received during that transfer |
| spi_fail | input | 1 | The transfer acknowledged now failed |

## Verification
A wrong page number or remaining count appears on the very next command frame as a wrong opcode or address byte. It also shows as a wrong number of frames before `done_o`. A timer or gap counter that does not reset or compare correctly shows within one poll interval, as status frames that come too close together or a timeout that fires early or never. A faulty status capture shows in the count of status frames per command, since a ready device must be polled exactly once more than it reports busy, plus once for each failed transfer.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

   typedef enum logic [3:0] {
      S_IDLE, S_DIV, S_STEP, S_CSEND, S_CWAIT,
      S_REL, S_PSEND, S_PWAIT, S_EVAL, S_GAP
   } seq_state_t;

   typedef enum logic [1:0] {
      ERR_NONE  = 2'd0,
      ERR_ALIGN = 2'd1,
      ERR_TMO   = 2'd2
   } err_kind_t;

   localparam logic [7:0] OPC_PAGE   = 8'h81;
   localparam logic [7:0] OPC_GROUP  = 8'h50;
   localparam logic [7:0] OPC_STATUS = 8'hD7;

   localparam int CMD_AW    = 24;
   localparam int GRP_PAGES = 8;
   localparam int GRP_LOG   = 3;
   localparam int CMD_BYTES = 4;
   localparam int STS_BYTES = 2;

endpackage

// File: rtl/erase_divmod.sv
module erase_divmod #(
   parameter int NUM_W = 24,
   parameter int DEN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             valid,
   output logic [NUM_W-1:0] quo,
   output logic [DEN_W-1:0] rem
);
   localparam int CNT_W = $clog2(NUM_W + 1);

   logic [DEN_W:0]   trial;
   logic [CNT_W-1:0] cnt;
   logic             run;

   assign trial = {rem, quo[NUM_W-1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quo   <= '0;
         rem   <= '0;
         cnt   <= '0;
         run   <= 1'b0;
         valid <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (go) begin
            quo <= num;
            rem <= '0;
            cnt <= CNT_W'(NUM_W);
            run <= 1'b1;
         end else if (run) begin
            if (trial >= {1'b0, den}) begin
               rem <= DEN_W'(trial - {1'b0, den});
               quo <= {quo[NUM_W-2:0], 1'b1};
            end else begin
               rem <= trial[DEN_W-1:0];
               quo <= {quo[NUM_W-2:0], 1'b0};
            end
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) begin
               run   <= 1'b0;
               valid <= 1'b1;
            end
         end
      end
   end

   // R1
   rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (rem < den))
      else $error("remainder not below divisor");

endmodule

// File: rtl/erase_step_pick.sv
module erase_step_pick
   import erase_seq_pkg::*;
#(
   parameter int PN_W = 24,
   parameter int SH_W = 4
) (
   input  logic [PN_W-1:0]   pn,
   input  logic [PN_W-1:0]   npg,
   input  logic [SH_W-1:0]   shift,
   output logic              grp,
   output logic [7:0]        opcode,
   output logic [CMD_AW-1:0] addr
);
   assign grp    = (pn[GRP_LOG-1:0] == '0) && (npg >= PN_W'(GRP_PAGES));
   assign opcode = grp ? OPC_GROUP : OPC_PAGE;

   generate
      if (PN_W < CMD_AW) begin : g_narrow
         assign addr = {{(CMD_AW-PN_W){1'b0}}, pn} << shift;
      end else begin : g_wide
         assign addr = pn[CMD_AW-1:0] << shift;
      end
   endgenerate

endmodule

// File: rtl/erase_seq.sv
module erase_seq
   import erase_seq_pkg::*;
#(
   parameter int ADDR_W      = 24,
   parameter int PS_W        = 12,
   parameter int SH_W        = 4,
   parameter int POLL_CYC    = 375000,
   parameter int TIMEOUT_CYC = 250000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] offset_in,
   input  logic [ADDR_W-1:0] length_in,
   input  logic [PS_W-1:0]   page_size_in,
   input  logic [SH_W-1:0]   page_shift_in,
   output logic              busy,
   output logic              done_o,
   output logic              err_o,
   output logic [1:0]        err_code,
   output logic              spi_cs,
   output logic              spi_req,
   output logic [7:0]        spi_tx,
   input  logic              spi_ack,
   input  logic [7:0]        spi_rx,
   input  logic              spi_fail
);
   localparam int TMR_W = $clog2(TIMEOUT_CYC + 1) + 1;
   localparam int GAP_W = $clog2(POLL_CYC + 1);
   localparam int BI_W  = $clog2(CMD_BYTES);

   initial begin
      assert (POLL_CYC >= 1) else $error("POLL_CYC must be at least 1");
      assert (TIMEOUT_CYC >= 1) else $error("TIMEOUT_CYC must be at least 1");
      assert (ADDR_W > GRP_LOG) else $error("ADDR_W too small");
      assert (PS_W >= 1 && PS_W < ADDR_W) else $error("PS_W out of range");
   end

   seq_state_t        state;
   err_kind_t         ecode;
   logic [ADDR_W-1:0] off_r, len_r, pn, npg;
   logic [PS_W-1:0]   ps_r;
   logic [SH_W-1:0]   sh_r;
   logic              div_go;
   logic [1:0]        dval;
   logic [ADDR_W-1:0] dnum [2];
   logic [ADDR_W-1:0] dquo [2];
   logic [PS_W-1:0]   drem [2];
   logic              grp_c, grp_r;
   logic [7:0]        opc_c, opc_r;
   logic [CMD_AW-1:0] adr_c, adr_r;
   logic [BI_W-1:0]   bidx;
   logic [7:0]        sts;
   logic [TMR_W-1:0]  tmr;
   logic [GAP_W-1:0]  gap;
   logic              in_wait;

   assign dnum[0] = off_r;
   assign dnum[1] = len_r;

   generate
      for (genvar gi = 0; gi < 2; gi++) begin : g_div
         erase_divmod #(.NUM_W(ADDR_W), .DEN_W(PS_W)) u_div (
            .clk  (clk),
            .rst_n(rst_n),
            .go   (div_go),
            .num  (dnum[gi]),
            .den  (ps_r),
            .valid(dval[gi]),
            .quo  (dquo[gi]),
            .rem  (drem[gi])
         );
      end
   endgenerate

   erase_step_pick #(.PN_W(ADDR_W), .SH_W(SH_W)) u_pick (
      .pn    (pn),
      .npg   (npg),
      .shift (sh_r),
      .grp   (grp_c),
      .opcode(opc_c),
      .addr  (adr_c)
   );

   assign busy     = (state != S_IDLE);
   assign err_code = ecode;
   assign spi_cs   = (state == S_CSEND) || (state == S_CWAIT) ||
                     (state == S_PSEND) || (state == S_PWAIT);
   assign spi_req  = (state == S_CSEND) || (state == S_PSEND);
   assign in_wait  = (state == S_REL) || (state == S_PSEND) || (state == S_PWAIT) ||
                     (state == S_EVAL) || (state == S_GAP);

   always_comb begin
      spi_tx = 8'h00;
      if (state == S_CSEND || state == S_CWAIT) begin
         case (bidx)
            BI_W'(0): spi_tx = opc_r;
            BI_W'(1): spi_tx = adr_r[23:16];
            BI_W'(2): spi_tx = adr_r[15:8];
            default:  spi_tx = 8'h00;
         endcase
      end else if (bidx == '0) begin
         spi_tx = OPC_STATUS;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         ecode  <= ERR_NONE;
         off_r  <= '0;
         len_r  <= '0;
         ps_r   <= '0;
         sh_r   <= '0;
         pn     <= '0;
         npg    <= '0;
         div_go <= 1'b0;
         grp_r  <= 1'b0;
         opc_r  <= '0;
         adr_r  <= '0;
         bidx   <= '0;
         sts    <= '0;
         tmr    <= '0;
         gap    <= '0;
         done_o <= 1'b0;
         err_o  <= 1'b0;
      end else begin
         div_go <= 1'b0;
         done_o <= 1'b0;
         err_o  <= 1'b0;
         if (in_wait && tmr != '1) tmr <= tmr + 1'b1;
         case (state)
            S_IDLE: if (start) begin
               off_r <= offset_in;
               len_r <= length_in;
               ps_r  <= page_size_in;
               sh_r  <= page_shift_in;
               if (page_size_in == '0) begin
                  ecode <= ERR_ALIGN;
                  err_o <= 1'b1;
               end else begin
                  ecode  <= ERR_NONE;
                  div_go <= 1'b1;
                  state  <= S_DIV;
               end
            end
            S_DIV: if (dval[0]) begin
               if (drem[0] != '0 || drem[1] != '0) begin
                  ecode <= ERR_ALIGN;
                  err_o <= 1'b1;
                  state <= S_IDLE;
               end else begin
                  pn    <= dquo[0];
                  npg   <= dquo[1];
                  state <= S_STEP;
               end
            end
            S_STEP: if (npg == '0) begin
               done_o <= 1'b1;
               state  <= S_IDLE;
            end else begin
               grp_r <= grp_c;
               opc_r <= opc_c;
               adr_r <= adr_c;
               bidx  <= '0;
               state <= S_CSEND;
            end
            S_CSEND: state <= S_CWAIT;
            S_CWAIT: if (spi_ack) begin
               if (bidx == BI_W'(CMD_BYTES - 1)) begin
                  tmr   <= '0;
                  state <= S_REL;
               end else begin
                  bidx  <= bidx + 1'b1;
                  state <= S_CSEND;
               end
            end
            S_REL: begin
               bidx  <= '0;
               state <= S_PSEND;
            end
            S_PSEND: state <= S_PWAIT;
            S_PWAIT: if (spi_ack) begin
               if (bidx == BI_W'(STS_BYTES - 1)) begin
                  sts   <= spi_fail ? 8'h00 : spi_rx;
                  state <= S_EVAL;
               end else begin
                  bidx  <= bidx + 1'b1;
                  state <= S_PSEND;
               end
            end
            S_EVAL: if (sts[7]) begin
               pn    <= pn + (grp_r ? ADDR_W'(GRP_PAGES) : ADDR_W'(1));
               npg   <= npg - (grp_r ? ADDR_W'(GRP_PAGES) : ADDR_W'(1));
               state <= S_STEP;
            end else if (tmr >= TMR_W'(TIMEOUT_CYC)) begin
               ecode <= ERR_TMO;
               err_o <= 1'b1;
               state <= S_IDLE;
            end else begin
               gap   <= '0;
               state <= S_GAP;
            end
            S_GAP: if (gap == GAP_W'(POLL_CYC - 1)) begin
               bidx  <= '0;
               state <= S_PSEND;
            end else begin
               gap <= gap + 1'b1;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   // R3
   req_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi_req |-> spi_cs)
      else $error("byte request outside a frame");

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o)
      else $error("done wider than one cycle");

   // R10
   end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o))
      else $error("done and error together");

   // R10
   code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE && $past(state) == S_IDLE && !$past(start)) |-> $stable(ecode))
      else $error("error code changed while idle");

   // R7
   advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_STEP && $past(state) == S_EVAL) |-> ((pn - $past(pn)) == ($past(npg) - npg)))
      else $error("page number and remaining count moved apart");

   // R6
   tmo_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && ecode == ERR_TMO) |-> ($past(tmr) >= TMR_W'(TIMEOUT_CYC)))
      else $error("timeout reported early");

endmodule

// File: tb/tb_erase_seq.sv
module tb_erase_seq;
   localparam int ADDR_W = 24;
   localparam int PS_W   = 12;
   localparam int SH_W   = 4;
   localparam int POLL   = 8;
   localparam int TMO    = 120;
   localparam int BUSY_N = 2;
   localparam int NV     = 10;

   // stimulus and expected outcome: page size, shift, offset, length, code, command count
   localparam int V_PS [NV] = '{264, 264, 264, 264, 264, 256, 264, 0, 528, 1056};
   localparam int V_SH [NV] = '{9, 9, 9, 9, 9, 8, 9, 9, 10, 11};
   localparam int V_OFF[NV] = '{0, 792, 1584, 100, 0, 4096, 264, 0, 4224, 4325376};
   localparam int V_LEN[NV] = '{2112, 528, 3168, 264, 300, 2048, 0, 264, 3696, 1056};
   localparam int V_EC [NV] = '{0, 0, 0, 1, 1, 0, 0, 1, 0, 0};
   localparam int V_NC [NV] = '{1, 2, 5, 0, 0, 1, 0, 0, 7, 1};

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [ADDR_W-1:0] offset_in = '0, length_in = '0;
   logic [PS_W-1:0] page_size_in = '0;
   logic [SH_W-1:0] page_shift_in = '0;
   logic busy, done_o, err_o, spi_cs, spi_req;
   logic [1:0] err_code;
   logic [7:0] spi_tx;
   logic spi_ack = 1'b0, spi_fail = 1'b0;
   logic [7:0] spi_rx = 8'h00;

   always #4 clk = ~clk;

   erase_seq #(.ADDR_W(ADDR_W), .PS_W(PS_W), .SH_W(SH_W),
               .POLL_CYC(POLL), .TIMEOUT_CYC(TMO)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .offset_in(offset_in),
      .length_in(length_in), .page_size_in(page_size_in),
      .page_shift_in(page_shift_in), .busy(busy), .done_o(done_o),
      .err_o(err_o), .err_code(err_code), .spi_cs(spi_cs),
      .spi_req(spi_req), .spi_tx(spi_tx), .spi_ack(spi_ack),
      .spi_rx(spi_rx), .spi_fail(spi_fail));

   int chk = 0, errs = 0, cyc = 0;
   int ncmd, npoll, badframe, npulse, min_gap, last_poll, cmd_end, end_cyc;
   logic [7:0]  cop [32];
   logic [23:0] cad [32];
   logic [7:0]  eop [32];
   logic [23:0] ead [32];
   int busy_left = 0, fail_cnt = 0;
   bit busy_forever = 0;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      chk++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // device and frame monitor, all on the falling edge
   initial begin
      bit in_frame = 0;
      int fcnt = 0, dly = 0;
      logic [7:0] fb [4];
      logic [7:0] prx = 8'h00;
      bit pfl = 0;
      last_poll = -1;
      forever begin
         @(negedge clk);
         cyc++;
         if (done_o || err_o) npulse++;
         if (spi_ack) begin spi_ack = 1'b0; spi_fail = 1'b0; spi_rx = 8'h00; end
         if (dly > 0) begin
            dly--;
            if (dly == 0) begin spi_ack = 1'b1; spi_rx = prx; spi_fail = pfl; end
         end
         if (spi_cs) begin
            if (!in_frame) begin in_frame = 1; fcnt = 0; end
            if (spi_req) begin
               prx = 8'h00; pfl = 0;
               if (fcnt == 0 && spi_tx == 8'hD7) begin
                  if (last_poll >= 0 && cyc - last_poll < min_gap) min_gap = cyc - last_poll;
                  last_poll = cyc;
               end
               if (fcnt == 1 && fb[0] == 8'hD7) begin
                  if (fail_cnt > 0) begin fail_cnt--; pfl = 1; prx = 8'hFF; end
                  else if (busy_forever || busy_left > 0) begin busy_left--; prx = 8'h7F; end
                  else prx = 8'hBC;
               end
               if (fcnt < 4) fb[fcnt] = spi_tx;
               fcnt++;
               dly = 2;
            end
         end else if (in_frame) begin
            in_frame = 0;
            if (fcnt == 4 && fb[0] != 8'hD7) begin
               if (fb[3] != 8'h00) badframe++;
               if (ncmd < 32) begin cop[ncmd] = fb[0]; cad[ncmd] = {fb[1], fb[2], 8'h00}; end
               ncmd++;
               busy_left = BUSY_N;
               cmd_end = cyc;
               last_poll = -1;
            end else if (fcnt == 2 && fb[0] == 8'hD7) begin
               if (fb[1] != 8'h00) badframe++;
               npoll++;
            end else badframe++;
         end
      end
   end

   task automatic model(input int off, input int len, input int ps, input int sh,
                        output int ec, output int en);
      int pn, np;
      en = 0;
      if (ps == 0 || off % ps != 0 || len % ps != 0) begin ec = 1; return; end
      ec = 0;
      pn = off / ps;
      np = len / ps;
      while (np > 0) begin
         bit g;
         g = (pn % 8 == 0) && (np >= 8);
         if (en < 32) begin
            eop[en] = g ? 8'h50 : 8'h81;
            ead[en] = 24'((pn << sh) & 32'hFFFF00);
         end
         en++;
         pn += g ? 8 : 1;
         np -= g ? 8 : 1;
      end
   endtask

   task automatic run_op(input int off, input int len, input int ps, input int sh, output int code);
      @(negedge clk);
      offset_in = ADDR_W'(off); length_in = ADDR_W'(len);
      page_size_in = PS_W'(ps); page_shift_in = SH_W'(sh);
      ncmd = 0; npoll = 0; badframe = 0; npulse = 0; min_gap = 1000000;
      start = 1'b1;
      code = 99;
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (i == 0) start = 1'b0;
         if (done_o) begin code = 0; end_cyc = cyc; break; end
         if (err_o) begin code = int'(err_code); end_cyc = cyc; break; end
      end
      if (code == 99) check(0, "R10 operation never ended", 0, 1);
      repeat (6) @(negedge clk);
   endtask

   initial begin
      #2000000;
      errs++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", chk, errs);
      $finish;
   end

   initial begin
      int code, ec, en;
      repeat (3) @(negedge clk);
      // R11 reset state
      check(!busy && !done_o && !err_o, "R11 idle outputs", {busy, done_o, err_o}, 0);
      check(!spi_cs && !spi_req && err_code == 2'd0, "R11 bus and code", {spi_cs, spi_req, err_code}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(!busy && !spi_cs && err_code == 2'd0, "R11 after release", {busy, spi_cs, err_code}, 0);

      for (int v = 0; v < NV; v++) begin
         model(V_OFF[v], V_LEN[v], V_PS[v], V_SH[v], ec, en);
         run_op(V_OFF[v], V_LEN[v], V_PS[v], V_SH[v], code);
         check(ec == V_EC[v] && en == V_NC[v], "table self-consistency", en, V_NC[v]);
         check(code == ec, (ec == 1) ? "R1 alignment code" : "R10 success code", code, ec);
         check(ncmd == en, (ec == 1) ? "R1 no frame on reject" : "R7 command count", ncmd, en);
         for (int k = 0; k < en && k < ncmd; k++) begin
            check(cop[k] == eop[k], "R2 erase opcode", cop[k], eop[k]);
            check(cad[k] == ead[k], "R3 command address", cad[k], ead[k]);
         end
         check(npoll == en * (BUSY_N + 1), "R4 status frames", npoll, en * (BUSY_N + 1));
         check(badframe == 0, "R3 R4 frame layout", badframe, 0);
         check(npulse == 1, "R10 single end pulse", npulse, 1);
         if (npoll > 1) check(min_gap >= POLL, "R5 poll spacing", min_gap, POLL);
      end

      // R8 failed status transfers count as not ready
      fail_cnt = 2;
      run_op(264, 264, 264, 9, code);
      check(code == 0, "R8 completes", code, 0);
      check(npoll == BUSY_N + 3, "R8 extra polls", npoll, BUSY_N + 3);

      // R9 start while busy is ignored
      fork
         run_op(264 * 5, 264 * 2, 264, 9, code);
         begin
            repeat (30) @(negedge clk);
            check(busy == 1'b1, "R9 still busy", busy, 1);
            offset_in = 24'd5; length_in = 24'd7; page_size_in = 12'd0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
         end
      join
      check(code == 0 && ncmd == 2, "R9 outcome unchanged", ncmd, 2);
      check(cad[1] == 24'h000C00 && cop[1] == 8'h81, "R9 second command", cad[1], 24'h000C00);
      check(npulse == 1, "R9 one end pulse", npulse, 1);

      // R6 device that never becomes ready
      busy_forever = 1;
      run_op(0, 528, 264, 9, code);
      busy_forever = 0;
      check(code == 2, "R6 timeout code", code, 2);
      check(ncmd == 1, "R6 no further command", ncmd, 1);
      check(end_cyc - cmd_end >= TMO, "R6 not early", end_cyc - cmd_end, TMO);
      check(end_cyc - cmd_end <= TMO + POLL + 20, "R6 not late", end_cyc - cmd_end, TMO + POLL + 20);
      check(min_gap >= POLL, "R5 poll spacing in timeout", min_gap, POLL);
      repeat (20) @(negedge clk);
      check(err_code == 2'd2 && !busy, "R10 code held", err_code, 2);

      run_op(0, 264, 264, 9, code);
      check(code == 0 && err_code == 2'd0, "R10 code cleared", err_code, 0);

      $display("CHECKS %0d ERRORS %0d", chk, errs);
      $finish;
   end
endmodule